// File: doc/BRIEF.md
# Interrupt Context Save/Restore Sequencer

This block performs the register-context switch around an interrupt handler. When the interrupt controller accepts an interrupt, the sequencer takes a snapshot of the live register file (A, B, C, workspace pointer, instruction pointer, status) and of the current CPU priority. It then stores context into the workspace of that handler and fetches the handler's own instruction pointer and status. These two words are kept permanently just below the handler workspace pointer. Finally it presents the new register values for one cycle with a load strobe. The handler always runs at high priority.

What is saved depends on what was interrupted. A high-priority process has its full six-word context written to memory. An idle CPU or a low-priority process gets only a single null status word in memory. A low-priority process also has its live state copied into an on-block shadow bank, which software can read and write one field at a time. On return from interrupt the sequencer reads the six-word frame back from the live workspace pointer. It resumes the saved high-priority process. If the frame holds a null status, it resumes instead from the shadow bank at low priority, or goes idle when the bank holds nothing valid. A one-cycle completion pulse goes back to the controller.

The memory side is a single-port word interface with a one-cycle read latency. The frame layout below the handler workspace pointer H is fixed:

| Address | Content |
|---|---|
| H-1 | handler instruction pointer |
| H-2 | handler status |
| H-3 | saved status |
| H-4 | saved instruction pointer |
| H-5 | saved workspace pointer |
| H-6 | saved C |
| H-7 | saved B |
| H-8 | saved A |

The handler starts with its workspace pointer at H-8.

Top module: `ictx_seq`

## Requirements
- R1: After reset, busy, mem_req, ctx_load, handler_start and ret_done are all 0, and sh_valid is 0.
- R2: An accept while cpu_pri is high (2'd2) gives six memory writes, one per cycle, starting the cycle after the accept. The writes go to addresses H-3, H-4, H-5, H-6, H-7 and H-8, and carry status, instruction pointer, workspace pointer, C, B and A in that order.
- R3: After saving, the sequencer reads H-1 and then H-2. It then raises ctx_load and handler_start together for one cycle. In that cycle out_ip holds the word from H-1, out_st holds the word from H-2, and out_wp is H-8. For a high-priority entry this cycle is the 10th after the accept edge.
- R4: An accept while cpu_pri is low (2'd1) or idle (2'd0) gives exactly one memory write: the null status (all ones) at H-3. ctx_load follows on the 5th cycle. On a low entry the shadow bank captures the live A, B, C, WP, IP and ST, and sh_valid becomes 1. On an idle entry sh_valid becomes 0.
- R5: During handler_start, out_pri is high (2'd2) for every interrupted priority.
- R6: A return request reads the six words at wp, wp+1 … wp+5, one per cycle, as A, B, C, WP, IP and ST. On the 8th cycle after the request edge, ctx_load and ret_done are 1 for one cycle. If the restored status is not null, the out_* ports hold the restored words and out_pri is 2'd2.
- R7: If the restored status is null, the block resumes from the shadow bank. With sh_valid at 1, out_* hold the shadow fields, out_pri is low (2'd1), and sh_valid clears. With sh_valid at 0, out_pri is idle (2'd0) and out_* are zero.
- R8: busy is 1 from the cycle after an accept or return request through the ctx_load cycle. An accept or return request that arrives while busy is ignored: it causes no memory traffic and does not change the handler address in use.
- R9: With sh_we at 1, the shadow field selected by sh_idx is written with sh_wdata and sh_valid is set. The fields are 0 A, 1 B, 2 C, 3 WP, 4 IP, 5 ST. sh_rdata shows the field selected by sh_idx combinationally.
- R10: If an accept and a return request arrive in the same idle cycle, the accept is taken and the return request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| acc_valid | input | 1 | interrupt accepted by controller |
| acc_hwp | input | DW | handler workspace pointer of the accepted interrupt |
| cpu_pri | input | 2 | current priority: 0 idle, 1 low, 2 high |
| reg_a | input | DW | live A |
| reg_b | input | DW | live B |
| reg_c | input | DW | live C |
| reg_wp | input | DW | live workspace pointer |
| reg_ip | input | DW | live instruction pointer |
| reg_st | input | DW | live status |
| ret_req | input | 1 | return-from-interrupt request |
| busy | output | 1 | sequence in progress |
| mem_req | output | 1 | memory access this cycle |
| mem_we | output | 1 | access is a write |
| mem_addr | output | DW | word address |
| mem_wdata | output | DW | write data |
| mem_rdata | input | DW | read data, one cycle after request |
| ctx_load | output | 1 | out_* and out_pri valid, load register file |
| handler_start | output | 1 | load belongs to a handler entry |
| out_a | output | DW | A to load |
| out_b | output | DW | B to load |
| out_c | output | DW | C to load |
| out_wp | output | DW | workspace pointer to load |
| out_ip | output | DW | instruction pointer to load |
| out_st | output | DW | status to load |
| out_pri | output | 2 | priority to run at |
| ret_done | output | 1 | return complete, to interrupt controller |
| sh_idx | input | 3 | shadow field select |
| sh_we | input | 1 | shadow field write strobe |
| sh_wdata | input | DW | shadow write data |
| sh_rdata | output | DW | selected shadow field |
| sh_valid | output | 1 | shadow bank holds a preempted process |

## Verification
Entry is tried from each of the three priorities. High entry is swept over four handler addresses and register patterns. Each field carries a distinct value, so a swapped save order or a wrong offset shows up as a wrong word at a known address. Every high entry is followed by a return from the handler's start workspace pointer. This tells a faithful reverse-order restore apart from a shifted or misordered one. Null entries from low and idle, and their returns, separate the three resume outcomes: saved frame, shadow bank and idle. A shadow bank filled through the software port shows that restore takes the shadow contents and not a stale capture. Accepts poked in the middle of a sequence, and an accept that coincides with a return request, show that traffic follows only the first request.

// File: rtl/ictx_pkg.sv
package ictx_pkg;
   typedef enum logic [1:0] {
      PRI_IDLE = 2'd0,
      PRI_LOW  = 2'd1,
      PRI_HIGH = 2'd2
   } pri_t;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_SAVE   = 3'd1,
      S_FETCH  = 3'd2,
      S_START  = 3'd3,
      S_REST   = 3'd4,
      S_FINISH = 3'd5
   } seq_t;

   // field numbering of a context: 0 A, 1 B, 2 C, 3 WP, 4 IP, 5 ST
   localparam int NFIELD   = 6;
   localparam int F_WP     = 3;
   localparam int F_IP     = 4;
   localparam int F_ST     = 5;
   // permanent handler words below the handler pointer
   localparam int NPERM    = 2;
   localparam int SAVE_OFS = NPERM + 1;
   localparam int FRAME_LO = NPERM + NFIELD;
endpackage

// File: rtl/ictx_shadow.sv
module ictx_shadow
   import ictx_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cap_en,
   input  logic                         cap_clr,
   input  logic                         consume,
   input  logic [NFIELD-1:0][DW-1:0]    cap_data,
   input  logic                         sw_we,
   input  logic [2:0]                   sw_idx,
   input  logic [DW-1:0]                sw_wdata,
   output logic [DW-1:0]                sw_rdata,
   output logic [NFIELD-1:0][DW-1:0]    sh_q,
   output logic                         sh_valid
);
   genvar f;
   generate
      for (f = 0; f < NFIELD; f++) begin : g_fld
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sh_q[f] <= '0;
            else if (cap_en)
               sh_q[f] <= cap_data[f];
            else if (sw_we && (sw_idx == 3'(f)))
               sh_q[f] <= sw_wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_valid <= 1'b0;
      else if (cap_en)
         sh_valid <= 1'b1;
      else if (cap_clr || consume)
         sh_valid <= 1'b0;
      else if (sw_we && (sw_idx < 3'(NFIELD)))
         sh_valid <= 1'b1;
   end

   always_comb begin
      sw_rdata = '0;
      for (int i = 0; i < NFIELD; i++)
         if (sw_idx == 3'(i)) sw_rdata = sh_q[i];
   end

   // R7: a resume from the bank leaves it empty
   p_consume_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      consume && !cap_en |=> !sh_valid);
   // R4: a low entry capture marks the bank valid
   p_capture_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> sh_valid);
endmodule

// File: rtl/ictx_memdrv.sv
module ictx_memdrv
   import ictx_pkg::*;
#(
   parameter int              DW      = 32,
   parameter logic [DW-1:0]   NULL_ST = '1
) (
   input  seq_t                         state,
   input  logic [2:0]                   idx,
   input  logic [DW-1:0]                base,
   input  logic                         isnull,
   input  logic [NFIELD-1:0][DW-1:0]    snap,
   output logic                         mem_req,
   output logic                         mem_we,
   output logic [DW-1:0]                mem_addr,
   output logic [DW-1:0]                mem_wdata
);
   logic [DW-1:0] ofs;
   assign ofs = DW'(idx);

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state)
         S_SAVE: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = base - DW'(SAVE_OFS) - ofs;
            mem_wdata = isnull ? NULL_ST : snap[3'd5 - idx];
         end
         S_FETCH: begin
            mem_req  = (idx < 3'd2);
            mem_addr = base - 1'b1 - ofs;
         end
         S_REST: begin
            mem_req  = (idx < 3'(NFIELD));
            mem_addr = base + ofs;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/ictx_ctrl.sv
module ictx_ctrl
   import ictx_pkg::*;
#(
   parameter int              DW      = 32,
   parameter logic [DW-1:0]   NULL_ST = '1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         acc_valid,
   input  logic [DW-1:0]                acc_hwp,
   input  logic [1:0]                   cpu_pri,
   input  logic [NFIELD-1:0][DW-1:0]    live,
   input  logic                         ret_req,
   input  logic [DW-1:0]                mem_rdata,
   input  logic [NFIELD-1:0][DW-1:0]    sh_q,
   input  logic                         sh_valid,
   output seq_t                         state,
   output logic [2:0]                   idx,
   output logic [DW-1:0]                base,
   output logic                         isnull,
   output logic [NFIELD-1:0][DW-1:0]    snap,
   output logic                         busy,
   output logic                         ctx_load,
   output logic                         handler_start,
   output logic                         ret_done,
   output logic [NFIELD-1:0][DW-1:0]    ctx_out,
   output logic [1:0]                   ctx_pri,
   output logic                         cap_en,
   output logic                         cap_clr,
   output logic                         consume
);
   logic [NFIELD-1:0][DW-1:0] rbuf;
   logic                      take_acc, take_ret, frame_null;

   assign take_acc   = (state == S_IDLE) && acc_valid;
   assign take_ret   = (state == S_IDLE) && !acc_valid && ret_req;
   assign frame_null = (rbuf[F_ST] == NULL_ST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         idx    <= '0;
         base   <= '0;
         isnull <= 1'b0;
         snap   <= '0;
         rbuf   <= '0;
      end else begin
         unique case (state)
            S_IDLE: begin
               idx <= '0;
               if (take_acc) begin
                  snap   <= live;
                  base   <= acc_hwp;
                  isnull <= (cpu_pri != PRI_HIGH);
                  state  <= S_SAVE;
               end else if (take_ret) begin
                  base  <= live[F_WP];
                  state <= S_REST;
               end
            end
            S_SAVE: begin
               if (isnull || idx == 3'(NFIELD - 1)) begin
                  idx   <= '0;
                  state <= S_FETCH;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            S_FETCH: begin
               idx <= idx + 1'b1;
               if (idx == 3'd1) rbuf[F_IP] <= mem_rdata;
               if (idx == 3'd2) begin
                  rbuf[F_ST] <= mem_rdata;
                  state      <= S_START;
               end
            end
            S_START:
               state <= S_IDLE;
            S_REST: begin
               if (idx != 3'd0) rbuf[idx - 3'd1] <= mem_rdata;
               if (idx == 3'(NFIELD)) state <= S_FINISH;
               else                   idx   <= idx + 1'b1;
            end
            S_FINISH:
               state <= S_IDLE;
            default:
               state <= S_IDLE;
         endcase
      end
   end

   assign busy          = (state != S_IDLE);
   assign ctx_load      = (state == S_START) || (state == S_FINISH);
   assign handler_start = (state == S_START);
   assign ret_done      = (state == S_FINISH);
   assign cap_en        = take_acc && (cpu_pri == PRI_LOW);
   assign cap_clr       = take_acc && (cpu_pri == PRI_IDLE);
   assign consume       = ret_done && frame_null && sh_valid;

   always_comb begin
      ctx_out = '0;
      ctx_pri = PRI_IDLE;
      if (state == S_START) begin
         ctx_out[2:0]  = snap[2:0];
         ctx_out[F_WP] = base - DW'(FRAME_LO);
         ctx_out[F_IP] = rbuf[F_IP];
         ctx_out[F_ST] = rbuf[F_ST];
         ctx_pri       = PRI_HIGH;
      end else if (state == S_FINISH) begin
         if (!frame_null) begin
            ctx_out = rbuf;
            ctx_pri = PRI_HIGH;
         end else if (sh_valid) begin
            ctx_out = sh_q;
            ctx_pri = PRI_LOW;
         end
      end
   end

   // R4: a null entry saves one word only, then goes straight to fetch
   p_null_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_SAVE) && isnull |=> (state == S_FETCH));
   // R8: a save in progress is never restarted by a new accept
   p_save_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_SAVE) |=> (state == S_SAVE) || (state == S_FETCH));
   // R8: the handler address in use is held while busy
   p_base_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (state != S_START) && (state != S_FINISH) |=> $stable(base));
endmodule

// File: rtl/ictx_seq.sv
module ictx_seq
   import ictx_pkg::*;
#(
   parameter int              DW      = 32,
   parameter logic [DW-1:0]   NULL_ST = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_valid,
   input  logic [DW-1:0]   acc_hwp,
   input  logic [1:0]      cpu_pri,
   input  logic [DW-1:0]   reg_a,
   input  logic [DW-1:0]   reg_b,
   input  logic [DW-1:0]   reg_c,
   input  logic [DW-1:0]   reg_wp,
   input  logic [DW-1:0]   reg_ip,
   input  logic [DW-1:0]   reg_st,
   input  logic            ret_req,
   output logic            busy,
   output logic            mem_req,
   output logic            mem_we,
   output logic [DW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   input  logic [DW-1:0]   mem_rdata,
   output logic            ctx_load,
   output logic            handler_start,
   output logic [DW-1:0]   out_a,
   output logic [DW-1:0]   out_b,
   output logic [DW-1:0]   out_c,
   output logic [DW-1:0]   out_wp,
   output logic [DW-1:0]   out_ip,
   output logic [DW-1:0]   out_st,
   output logic [1:0]      out_pri,
   output logic            ret_done,
   input  logic [2:0]      sh_idx,
   input  logic            sh_we,
   input  logic [DW-1:0]   sh_wdata,
   output logic [DW-1:0]   sh_rdata,
   output logic            sh_valid
);
   generate
      if (DW < 8) begin : g_bad_width
         $error("ictx_seq: DW must be at least 8");
      end
   endgenerate

   logic [NFIELD-1:0][DW-1:0] live, snap, sh_q, ctx_out;
   seq_t                      state;
   logic [2:0]                idx;
   logic [DW-1:0]             base;
   logic                      isnull, cap_en, cap_clr, consume;

   assign live = {reg_st, reg_ip, reg_wp, reg_c, reg_b, reg_a};

   ictx_ctrl #(.DW(DW), .NULL_ST(NULL_ST)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hwp(acc_hwp),
      .cpu_pri(cpu_pri), .live(live), .ret_req(ret_req), .mem_rdata(mem_rdata),
      .sh_q(sh_q), .sh_valid(sh_valid), .state(state), .idx(idx), .base(base),
      .isnull(isnull), .snap(snap), .busy(busy), .ctx_load(ctx_load),
      .handler_start(handler_start), .ret_done(ret_done), .ctx_out(ctx_out),
      .ctx_pri(out_pri), .cap_en(cap_en), .cap_clr(cap_clr), .consume(consume)
   );

   ictx_memdrv #(.DW(DW), .NULL_ST(NULL_ST)) u_mem (
      .state(state), .idx(idx), .base(base), .isnull(isnull), .snap(snap),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata)
   );

   ictx_shadow #(.DW(DW)) u_sh (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_clr(cap_clr),
      .consume(consume), .cap_data(live), .sw_we(sh_we), .sw_idx(sh_idx),
      .sw_wdata(sh_wdata), .sw_rdata(sh_rdata), .sh_q(sh_q), .sh_valid(sh_valid)
   );

   assign out_a  = ctx_out[0];
   assign out_b  = ctx_out[1];
   assign out_c  = ctx_out[2];
   assign out_wp = ctx_out[F_WP];
   assign out_ip = ctx_out[F_IP];
   assign out_st = ctx_out[F_ST];

   // R2: every access of a save step is a write
   p_save_writes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_SAVE) |-> mem_req && mem_we);
   // R5: a handler always starts at high priority
   p_handler_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      handler_start |-> (out_pri == 2'd2));
   // R6: completion is a single pulse and frees the block
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ret_done |=> !ret_done && !busy);
   // R8: no memory traffic while idle
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);
endmodule

// File: tb/sim_ictx_seq.sv
`timescale 1ns/100ps
module sim_ictx_seq;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          acc_valid = 0, ret_req = 0, sh_we = 0;
   logic [DW-1:0] acc_hwp = '0, sh_wdata = '0;
   logic [1:0]    cpu_pri = 2'd0;
   logic [DW-1:0] reg_a = 0, reg_b = 0, reg_c = 0, reg_wp = 0, reg_ip = 0, reg_st = 0;
   logic [2:0]    sh_idx = 3'd0;
   logic          busy, mem_req, mem_we, ctx_load, handler_start, ret_done, sh_valid;
   logic [DW-1:0] mem_addr, mem_wdata, mem_rdata, sh_rdata;
   logic [DW-1:0] out_a, out_b, out_c, out_wp, out_ip, out_st;
   logic [1:0]    out_pri;

   ictx_seq #(.DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hwp(acc_hwp),
      .cpu_pri(cpu_pri), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
      .reg_wp(reg_wp), .reg_ip(reg_ip), .reg_st(reg_st), .ret_req(ret_req),
      .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ctx_load(ctx_load),
      .handler_start(handler_start), .out_a(out_a), .out_b(out_b), .out_c(out_c),
      .out_wp(out_wp), .out_ip(out_ip), .out_st(out_st), .out_pri(out_pri),
      .ret_done(ret_done), .sh_idx(sh_idx), .sh_we(sh_we), .sh_wdata(sh_wdata),
      .sh_rdata(sh_rdata), .sh_valid(sh_valid)
   );

   // simple word memory, one cycle read latency
   logic [DW-1:0] mem [0:255];
   logic [DW-1:0] rd_q = '0;
   int wr_cnt = 0, rd_cnt = 0;
   assign mem_rdata = rd_q;
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_cnt = wr_cnt + 1;
         end else begin
            rd_cnt = rd_cnt + 1;
         end
         rd_q <= mem[mem_addr[7:0]];
      end
   end

   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] fld(input int s, input int f);
      return 32'h00A0_0000 + 32'(s * 256 + f * 16 + 3);
   endfunction

   task automatic set_live(input int s);
      reg_a = fld(s, 0); reg_b = fld(s, 1); reg_c = fld(s, 2);
      reg_wp = fld(s, 3); reg_ip = fld(s, 4); reg_st = fld(s, 5);
   endtask

   function automatic logic [DW-1:0] outf(input int f);
      case (f)
         0: return out_a;  1: return out_b;  2: return out_c;
         3: return out_wp; 4: return out_ip; default: return out_st;
      endcase
   endfunction

   // accept an interrupt; poke re-accepts mid-sequence, with_ret raises return too
   task automatic do_accept(input logic [DW-1:0] hwp, input logic [1:0] pri,
                            input int s, input bit poke, input bit with_ret,
                            output int lat);
      mem[hwp[7:0] - 8'd1] = 32'hC0DE_0000 + hwp;
      mem[hwp[7:0] - 8'd2] = 32'h5A00_0000 + hwp;
      @(negedge clk);
      wr_cnt = 0; rd_cnt = 0;
      acc_valid = 1; acc_hwp = hwp; cpu_pri = pri; set_live(s);
      ret_req = with_ret;
      @(negedge clk);
      acc_valid = 0; ret_req = 0;
      set_live(s + 100);
      lat = 1;
      chk(busy == 1'b1, "R8 busy after accept", 32'(busy), 32'd1);
      while (!ctx_load && lat < 40) begin
         if (poke && lat == 2) begin
            acc_valid = 1; acc_hwp = hwp + 32'd40; ret_req = 1;
         end else begin
            acc_valid = 0; ret_req = 0;
         end
         @(negedge clk);
         lat++;
      end
      acc_valid = 0; ret_req = 0;
      chk(handler_start == 1'b1, "R3 handler_start with load", 32'(handler_start), 32'd1);
      chk(out_ip == 32'hC0DE_0000 + hwp, "R3 handler ip", out_ip, 32'hC0DE_0000 + hwp);
      chk(out_st == 32'h5A00_0000 + hwp, "R3 handler status", out_st, 32'h5A00_0000 + hwp);
      chk(out_wp == hwp - 32'd8, "R3 handler wp", out_wp, hwp - 32'd8);
      chk(out_pri == 2'd2, "R5 handler priority", 32'(out_pri), 32'd2);
      @(negedge clk);
      chk(busy == 1'b0 && !ctx_load, "R8 busy clears after load", 32'(busy), 32'd0);
   endtask

   task automatic do_return(input logic [DW-1:0] wp, output int lat);
      @(negedge clk);
      wr_cnt = 0; rd_cnt = 0;
      ret_req = 1; reg_wp = wp;
      @(negedge clk);
      ret_req = 0;
      lat = 1;
      while (!ret_done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      chk(ctx_load == 1'b1, "R6 load with ret_done", 32'(ctx_load), 32'd1);
      chk(rd_cnt == 6 && wr_cnt == 0, "R6 six reads", 32'(rd_cnt), 32'd6);
      chk(lat == 8, "R6 return latency", 32'(lat), 32'd8);
   endtask

   initial begin
      int lat;
      logic [DW-1:0] h;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !mem_req, "R1 reset busy/mem_req", 32'(busy), 32'd0);
      chk(!ctx_load && !handler_start && !ret_done, "R1 reset strobes", 32'(ctx_load), 32'd0);
      chk(!sh_valid, "R1 reset sh_valid", 32'(sh_valid), 32'd0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R2/R3/R6: high-priority entry and return, swept over four frames
      for (int k = 0; k < 4; k++) begin
         h = 32'd40 + 32'(k * 24);
         do_accept(h, 2'd2, k, 0, 0, lat);
         chk(lat == 10, "R3 high entry latency", 32'(lat), 32'd10);
         chk(wr_cnt == 6 && rd_cnt == 2, "R2 six writes two reads", 32'(wr_cnt), 32'd6);
         for (int j = 0; j < 6; j++)
            chk(mem[h[7:0] - 8'(3 + j)] == fld(k, 5 - j), "R2 saved word order",
                mem[h[7:0] - 8'(3 + j)], fld(k, 5 - j));
         do_return(h - 32'd8, lat);
         chk(out_pri == 2'd2, "R6 resume high", 32'(out_pri), 32'd2);
         for (int f = 0; f < 6; f++)
            chk(outf(f) == fld(k, f), "R6 restored field", outf(f), fld(k, f));
      end

      // R8: accept and return poked while busy are ignored
      h = 32'd150;
      mem[h[7:0] + 8'd37] = 32'h1111_2222;
      do_accept(h, 2'd2, 7, 1, 0, lat);
      chk(wr_cnt == 6 && rd_cnt == 2, "R8 no extra traffic", 32'(wr_cnt), 32'd6);
      chk(mem[h[7:0] + 8'd37] == 32'h1111_2222, "R8 poked frame untouched",
          mem[h[7:0] + 8'd37], 32'h1111_2222);
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req, "R8 poked request dropped", 32'(busy), 32'd0);

      // R4/R7: low-priority entry, shadow capture, resume at low
      h = 32'd200;
      do_accept(h, 2'd1, 9, 0, 0, lat);
      chk(lat == 5, "R4 null entry latency", 32'(lat), 32'd5);
      chk(wr_cnt == 1, "R4 single write", 32'(wr_cnt), 32'd1);
      chk(mem[h[7:0] - 8'd3] == '1, "R4 null status word", mem[h[7:0] - 8'd3], '1);
      chk(sh_valid == 1'b1, "R4 shadow valid", 32'(sh_valid), 32'd1);
      for (int f = 0; f < 6; f++) begin
         sh_idx = 3'(f); #1;
         chk(sh_rdata == fld(9, f), "R4 shadow capture", sh_rdata, fld(9, f));
      end
      do_return(h - 32'd8, lat);
      chk(out_pri == 2'd1, "R7 resume low", 32'(out_pri), 32'd1);
      for (int f = 0; f < 6; f++)
         chk(outf(f) == fld(9, f), "R7 shadow fields out", outf(f), fld(9, f));
      @(negedge clk);
      chk(sh_valid == 1'b0, "R7 shadow consumed", 32'(sh_valid), 32'd0);

      // R4/R7: idle entry then return to idle
      h = 32'd120;
      do_accept(h, 2'd0, 11, 0, 0, lat);
      chk(wr_cnt == 1 && sh_valid == 1'b0, "R4 idle entry", 32'(sh_valid), 32'd0);
      do_return(h - 32'd8, lat);
      chk(out_pri == 2'd0 && out_wp == '0, "R7 resume idle", 32'(out_pri), 32'd0);

      // R9: software-written shadow, then resume from it
      do_accept(h, 2'd0, 12, 0, 0, lat);
      for (int f = 0; f < 6; f++) begin
         @(negedge clk);
         sh_we = 1; sh_idx = 3'(f); sh_wdata = 32'h7700_0000 + 32'(f);
      end
      @(negedge clk);
      sh_we = 0;
      chk(sh_valid == 1'b1, "R9 write sets valid", 32'(sh_valid), 32'd1);
      sh_idx = 3'd4; #1;
      chk(sh_rdata == 32'h7700_0004, "R9 readback", sh_rdata, 32'h7700_0004);
      do_return(h - 32'd8, lat);
      chk(out_pri == 2'd1 && out_c == 32'h7700_0002, "R9 resume from written bank",
          out_c, 32'h7700_0002);

      // R10: accept wins over simultaneous return
      h = 32'd90;
      do_accept(h, 2'd2, 13, 0, 1, lat);
      chk(wr_cnt == 6 && lat == 10, "R10 accept taken", 32'(wr_cnt), 32'd6);
      repeat (3) @(negedge clk);
      chk(!busy, "R10 return dropped", 32'(busy), 32'd0);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule